// File: doc/BRIEF.md
# Infrared Controller Interrupt Status and Enable Unit

This unit gathers the five event sources of an infrared link controller into two byte-wide registers that software reads and writes: a pending-status register and an enable register. The data path delivers each event as a one-cycle pulse. Each pulse latches into a sticky status bit, whatever the enable state. Software clears pending bits by writing ones to the status register. It selects which sources may interrupt by loading the enable register. A single registered, level-sensitive interrupt line is asserted while any pending bit is also enabled.

The transmit-done event is special. It is latched only when the transmit slot that just completed had asked for an interrupt. The data path presents that per-slot request flag in the same cycle as the transmit-done pulse. The five event bits occupy the upper five bits of each register. The three lowest bits of both registers always read as ones.

Top module: `irq_evt_unit`

## Requirements
- R1: After reset, the status register (offset 0xc) and the enable register (offset 0xd) both read 0x07, and `irqOut` is low.
- R2: Both registers use the same bit layout: bit 7 is transmit done, bit 6 receive done, bit 5 transmit underrun, bit 4 receive overflow and bit 3 serial gap received. Bits 2..0 read as 1 at offsets 0xc and 0xd. Every other offset reads 0x00. Readback is combinational from the register state.
- R3: An event pulse sampled at a rising clock edge sets its status bit. The bit reads back as set from that edge onward and stays set until it is cleared. This happens whether or not the source is enabled.
- R4: A transmit-done pulse sets status bit 7 only if `txSlotIrqReq` is high in the same cycle. Otherwise the pulse has no effect.
- R5: Writing to offset 0xc clears every status bit that is written as 1 (bits 7..3). Bits written as 0 keep their value. Data bits 2..0 are ignored.
- R6: If an event pulse arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R7: Writing to offset 0xd loads bits 7..3 of the written data into the enable register. A value of 0 disables every source.
- R8: `irqOut` goes high one clock after any status bit and its enable bit are both 1. It goes low one clock after no such pair remains.
- R9: A write to any offset other than 0xc or 0xd changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe for this cycle |
| regAddr | input | ADDR_W (5) | Register offset for both read and write |
| wrData | input | DATA_W (8) | Write data |
| rdData | output | DATA_W (8) | Combinational readback of the register at `regAddr` |
| txDoneEvt | input | 1 | Transmit slot completed, one-cycle pulse |
| txSlotIrqReq | input | 1 | The completed transmit slot requested an interrupt |
| rxDoneEvt | input | 1 | Receive completed, one-cycle pulse |
| txUnderEvt | input | 1 | Transmit FIFO underrun, one-cycle pulse |
| rxOverEvt | input | 1 | Receive FIFO overflow, one-cycle pulse |
| gapEvt | input | 1 | Serial gap received, one-cycle pulse |
| irqOut | output | 1 | Registered interrupt level |

## Verification
Status and enable updates happen at the clock edge that samples the pulse or the write. Their readback is due as soon as that edge has passed. `irqOut` trails by exactly one more edge, because it is registered from the register state. The bench drives every input just after a falling edge and samples `rdData` and `irqOut` two nanoseconds later. It updates its own model of both registers and of the interrupt flop at each rising edge, so every comparison is made against the state from before the coming edge. Constrained-random cycles mix writes to both offsets and to unused offsets with sparse event pulses. They run alongside directed cases for set-and-clear collisions, transmit done without a request, and enabling and disabling a source that is already pending.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int NUM_EVT = 5;
  // Event vector index; register bit = index + (DATA_W - NUM_EVT)
  localparam int EV_GAP     = 0;
  localparam int EV_RXOVER  = 1;
  localparam int EV_TXUNDER = 2;
  localparam int EV_RXDONE  = 3;
  localparam int EV_TXDONE  = 4;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic selStatus;
    logic selEnable;
  } regStrobe_t;
endpackage

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 5'h0c,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 5'h0d
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobes
);
  logic hitStatus;
  logic hitEnable;

  always_comb begin
    hitStatus = (regAddr == STATUS_OFS);
    hitEnable = (regAddr == ENABLE_OFS);
    strobes.selStatus = hitStatus;
    strobes.selEnable = hitEnable;
    strobes.wrStatus  = wrEn && hitStatus;
    strobes.wrEnable  = wrEn && hitEnable;
  end
endmodule

// File: rtl/irq_evt_dp.sv
module irq_evt_dp
  import irq_evt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobes,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_EVT-1:0] evtRaw,
  input  logic               txSlotIrqReq,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_EVT-1:0] statusQ,
  output logic [NUM_EVT-1:0] enableQ,
  output logic               irqOut
);
  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] evtQual;
  logic [NUM_EVT-1:0] clrMask;

  always_comb begin
    evtQual = evtRaw;
    evtQual[EV_TXDONE] = evtRaw[EV_TXDONE] & txSlotIrqReq;
    clrMask = strobes.wrStatus ? wrData[DATA_W-1 -: NUM_EVT] : '0;
  end

  // one sticky flop per source; set wins over clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           statusQ[i] <= 1'b0;
      else if (evtQual[i]) statusQ[i] <= 1'b1;
      else if (clrMask[i]) statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 enableQ <= '0;
    else if (strobes.wrEnable) enableQ <= wrData[DATA_W-1 -: NUM_EVT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(statusQ & enableQ);
  end

  always_comb begin
    if (strobes.selStatus)      rdData = {statusQ, {PAD_W{1'b1}}};
    else if (strobes.selEnable) rdData = {enableQ, {PAD_W{1'b1}}};
    else                        rdData = '0;
  end
endmodule

// File: rtl/irq_evt_unit.sv
module irq_evt_unit
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 5'h0c,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 5'h0d
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              txDoneEvt,
  input  logic              txSlotIrqReq,
  input  logic              rxDoneEvt,
  input  logic              txUnderEvt,
  input  logic              rxOverEvt,
  input  logic              gapEvt,
  output logic              irqOut
);
  regStrobe_t         strobes;
  logic [NUM_EVT-1:0] evtVec;
  logic [NUM_EVT-1:0] statusVec;
  logic [NUM_EVT-1:0] enableVec;

  always_comb begin
    evtVec             = '0;
    evtVec[EV_TXDONE]  = txDoneEvt;
    evtVec[EV_RXDONE]  = rxDoneEvt;
    evtVec[EV_TXUNDER] = txUnderEvt;
    evtVec[EV_RXOVER]  = rxOverEvt;
    evtVec[EV_GAP]     = gapEvt;
  end

  irq_evt_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS)
  ) u_ctrl (
    .wrEn(wrEn), .regAddr(regAddr), .strobes(strobes)
  );

  irq_evt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .evtRaw(evtVec), .txSlotIrqReq(txSlotIrqReq), .rdData(rdData),
    .statusQ(statusVec), .enableQ(enableVec), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_evt_chk.sv
module irq_evt_chk
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 5'h0c,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 5'h0d
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_EVT-1:0] evtVec,
  input logic               txSlotIrqReq,
  input logic [NUM_EVT-1:0] statusVec,
  input logic [NUM_EVT-1:0] enableVec,
  input logic               irqOut
);
  logic [NUM_EVT-1:0] evtG;
  always_comb begin
    evtG = evtVec;
    evtG[EV_TXDONE] = evtVec[EV_TXDONE] & txSlotIrqReq;
  end

  // R2
  pad_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STATUS_OFS || regAddr == ENABLE_OFS) |-> rdData[2:0] == 3'b111);

  // R3
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtG != '0) |=> (statusVec & $past(evtG)) == $past(evtG));

  // R4
  txdone_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec[EV_TXDONE] && !txSlotIrqReq && !statusVec[EV_TXDONE]) |=> !statusVec[EV_TXDONE]);

  // R5
  no_clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == STATUS_OFS) |=> (statusVec & $past(statusVec)) == $past(statusVec));

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == STATUS_OFS) |=>
      (statusVec & $past(wrData[DATA_W-1 -: NUM_EVT]) & ~$past(evtG)) == '0);

  // R7
  enable_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ENABLE_OFS) |=> enableVec == $past(wrData[DATA_W-1 -: NUM_EVT]));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|(statusVec & enableVec)));
endmodule

bind irq_evt_unit irq_evt_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .rdData(rdData), .evtVec(evtVec), .txSlotIrqReq(txSlotIrqReq),
  .statusVec(statusVec), .enableVec(enableVec), .irqOut(irqOut)
);

// File: tb/irq_evt_unit_test.sv
`timescale 1ns/1ps
module irq_evt_unit_test;
  localparam logic [4:0] ST = 5'h0c;
  localparam logic [4:0] EN = 5'h0d;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic txDoneEvt = 0, txSlotIrqReq = 0, rxDoneEvt = 0, txUnderEvt = 0, rxOverEvt = 0, gapEvt = 0;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model: bits ordered txdone, rxdone, underrun, overflow, gap (reg bits 7..3)
  logic [4:0] expSt = '0;
  logic [4:0] expEn = '0;
  logic expIrq = 1'b0;

  always #10 clk = ~clk;

  irq_evt_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .txDoneEvt(txDoneEvt), .txSlotIrqReq(txSlotIrqReq),
    .rxDoneEvt(rxDoneEvt), .txUnderEvt(txUnderEvt), .rxOverEvt(rxOverEvt),
    .gapEvt(gapEvt), .irqOut(irqOut)
  );

  function automatic logic [7:0] expRead(input logic [4:0] a);
    if (a == ST) return {expSt, 3'b111};
    if (a == EN) return {expEn, 3'b111};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // evt: {txdone, rxdone, underrun, overflow, gap}
  task automatic cycle(input string tag, input bit wr, input logic [4:0] a,
                       input logic [7:0] d, input logic [4:0] evt, input bit req);
    logic [4:0] q;
    logic [4:0] clr;
    @(negedge clk);
    wrEn = wr; regAddr = a; wrData = d;
    {txDoneEvt, rxDoneEvt, txUnderEvt, rxOverEvt, gapEvt} = evt;
    txSlotIrqReq = req;
    #2;
    check("R8 irqOut", {7'd0, irqOut}, {7'd0, expIrq});
    if (!wr) check(tag, rdData, expRead(a));
    @(posedge clk);
    q = evt; q[4] = evt[4] & req;
    clr = (wr && a == ST) ? d[7:3] : 5'd0;
    expIrq = |(expSt & expEn);
    expSt = (expSt & ~clr) | q;
    if (wr && a == EN) expEn = d[7:3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset values
    cycle("R1 status reset", 0, ST, 0, 5'b0, 0);
    cycle("R1 enable reset", 0, EN, 0, 5'b0, 0);
    // R3 gap event with source disabled
    cycle("R3 pulse", 0, 5'h00, 0, 5'b00001, 0);
    cycle("R3 gap sticky 0x0f", 0, ST, 0, 5'b0, 0);
    cycle("R3 still set", 0, ST, 0, 5'b0, 0);
    // R4 txdone without request ignored, with request sets bit 7
    cycle("R4 no req", 0, 5'h00, 0, 5'b10000, 0);
    cycle("R4 txdone ignored", 0, ST, 0, 5'b0, 0);
    cycle("R4 with req", 0, 5'h00, 0, 5'b10000, 1);
    cycle("R2 txdone at bit7", 0, ST, 0, 5'b0, 0);
    // R2 each remaining source lands on its bit
    cycle("R2 rxdone", 0, 5'h00, 0, 5'b01000, 0);
    cycle("R2 bit6", 0, ST, 0, 5'b0, 0);
    cycle("R2 under+over", 0, 5'h00, 0, 5'b00110, 0);
    cycle("R2 bits5,4", 0, ST, 0, 5'b0, 0);
    // R5 writing zeros has no effect; then clear bit7 only
    cycle("R5", 1, ST, 8'h07, 5'b0, 0);
    cycle("R5 zeros no effect", 0, ST, 0, 5'b0, 0);
    cycle("R5", 1, ST, 8'h80, 5'b0, 0);
    cycle("R5 bit7 cleared", 0, ST, 0, 5'b0, 0);
    // R6 collision: rxdone pulse while clearing rxdone
    cycle("R6", 1, ST, 8'h40, 5'b01000, 0);
    cycle("R6 set wins", 0, ST, 0, 5'b0, 0);
    // R7 / R8 enable pending source, irq rises next edge
    cycle("R7", 1, EN, 8'hff, 5'b0, 0);
    cycle("R7 enable readback", 0, EN, 0, 5'b0, 0);
    cycle("R8 irq high", 0, EN, 0, 5'b0, 0);
    cycle("R7", 1, EN, 8'h00, 5'b0, 0);
    cycle("R7 all disabled", 0, EN, 0, 5'b0, 0);
    cycle("R8 irq low", 0, ST, 0, 5'b0, 0);
    // R9 writes elsewhere ignored; R2 other offsets read zero
    cycle("R9", 1, 5'h03, 8'hff, 5'b0, 0);
    cycle("R9", 1, 5'h0e, 8'hff, 5'b0, 0);
    cycle("R9 status unchanged", 0, ST, 0, 5'b0, 0);
    cycle("R9 enable unchanged", 0, EN, 0, 5'b0, 0);
    cycle("R2 other offset zero", 0, 5'h03, 0, 5'b0, 0);
    // R8 clear all with enable on
    cycle("R8", 1, EN, 8'h08, 5'b0, 0);
    cycle("R8", 1, ST, 8'hff, 5'b0, 0);
    cycle("R8 after clear", 0, ST, 0, 5'b0, 0);
    cycle("R8 low again", 0, ST, 0, 5'b0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      logic [4:0] ev;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? ST : (sel < 8) ? EN : 5'($urandom_range(0, 31));
      ev = 5'($urandom) & 5'($urandom) & 5'($urandom);
      cycle("R3 R5 R7 random", ($urandom_range(0, 2) == 0), a, 8'($urandom),
            ev, 1'($urandom));
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule